// File: doc/BRIEF.md
# Instruction Cache Parity Guard

This block holds a small direct-mapped instruction cache array and protects every entry with two parity bits. One bit covers the stored tag and the other covers the stored data word. Each fill computes even parity and writes it beside the entry. Each fetch looks up the entry and checks both parity bits against the stored contents. A registered response returns the hit flag and the data one cycle after the fetch.

A small configuration register controls the checks. One bit turns checking on, and any parity failure found then sets a sticky status bit. A second bit escalates those failures to a one-cycle machine-check pulse. Two more bits corrupt the parity written on the next fills, one for data and one for tag, so the error paths can be tested. Replacement, bus interfacing and exception vectoring are left to the surrounding logic.

Top module: `icache_parity_ctrl`

## Requirements
- R1: A fetch presented with `fetch_valid` returns its response one cycle later with `fetch_rvalid`=1. The address is split into index = `addr[3:0]` and tag = `addr[11:4]`. If the entry at the index is valid and its tag matches, the response has `fetch_hit`=1 and `fetch_rdata` equal to the filled word.
- R2: A fetch whose index holds no valid entry, or holds a different tag, returns `fetch_hit`=0 and `fetch_rdata`=0.
- R3: A fill always stores even parity for tag and data, whatever the checking setting. A clean entry filled while checking is off raises no error when it is later fetched with checking on.
- R4: While data injection is set (config bit 2), fills store inverted data parity. A hitting fetch of such an entry with checking on sets status bit 0 (data error) in the cycle after the fetch.
- R5: While tag injection is set (config bit 3), fills store inverted tag parity. A fetch of that index with checking on sets status bit 1 (tag error), even when the tag comparison misses.
- R6: A fetch that misses in the tag comparison never reports a data parity error.
- R7: While check enable (config bit 0) is clear, parity errors change neither the status nor `mcheck`.
- R8: With check enable and escalate enable (config bit 1) both set, a failing fetch drives `mcheck` high for exactly one cycle, aligned with its response. With escalate enable clear, the status is set but `mcheck` stays low.
- R9: A fetch marked speculative (`fetch_spec`=1) is checked and reported exactly like a normal fetch.
- R10: Status bits are sticky. Writing config with bit 4 set clears status bit 0, and writing it with bit 5 set clears status bit 1. Writing 0 to those bits leaves the status unchanged. A new error arriving in the same cycle as a clear wins.
- R11: After reset, all entries are invalid, the configuration is zero, and `fetch_rvalid`, `fetch_hit`, `fetch_rdata`, `perr_status` and `mcheck` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Write one entry this cycle |
| fill_addr | input | 12 | Fill address (tag and index) |
| fill_data | input | 32 | Word to store |
| fetch_valid | input | 1 | Look up one entry this cycle |
| fetch_addr | input | 12 | Fetch address (tag and index) |
| fetch_spec | input | 1 | Fetch is speculative |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Bit 0 check enable, bit 1 escalate enable, bit 2 data injection, bit 3 tag injection, bit 4 clear data status, bit 5 clear tag status |
| fetch_rvalid | output | 1 | Response valid, one cycle after the fetch |
| fetch_rdata | output | 32 | Fetched word (0 on miss) |
| fetch_hit | output | 1 | Tag matched on a valid entry |
| perr_status | output | 2 | Sticky errors: bit 0 data, bit 1 tag |
| mcheck | output | 1 | One-cycle machine-check pulse |

## Verification
The assertions are evaluated on every cycle. They check that every fetch gets its response on the next cycle and that no response appears without a fetch. They check that a machine-check pulse only comes with a response, and only when both enables were set. They also check that a status bit never rises unless a fetch was made with checking on, and never falls unless a clear was written. Only the directed scenarios can show the rest. That covers which entries have bad parity after injection, the rule that a tag miss suppresses the data error while the tag error is still reported, speculative fetches, and the new error winning over a clear in the same cycle.

// File: rtl/icp_pkg.sv
// Shared constants and types for the instruction cache parity guard.
// Assumes a 6-bit configuration word; bit positions are fixed here only.
package icp_pkg;
    localparam int CFG_W    = 6;
    localparam int CB_CHK   = 0;
    localparam int CB_ESC   = 1;
    localparam int CB_INJ_D = 2;
    localparam int CB_INJ_T = 3;
    localparam int CB_CLR_D = 4;
    localparam int CB_CLR_T = 5;
    localparam int ST_DATA  = 0;
    localparam int ST_TAG   = 1;
    localparam int ST_W     = 2;

    typedef struct packed {
        logic inj_tag;
        logic inj_data;
        logic esc_en;
        logic chk_en;
    } icp_cfg_t;
endpackage

// File: rtl/icp_cfg_regs.sv
// Configuration register and sticky parity-error status.
// Assumes set requests arrive as single-cycle pulses; a set beats a clear.
module icp_cfg_regs
    import icp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              set_data_err,
    input  logic              set_tag_err,
    output icp_cfg_t          cfg_q,
    output logic [ST_W-1:0]   status_q
);
    logic [ST_W-1:0] clr_req;
    logic [ST_W-1:0] set_req;

    // Decode write-one-to-clear requests and incoming error pulses
    always_comb begin
        clr_req = '0;
        set_req = '0;
        clr_req[ST_DATA] = cfg_we && cfg_wdata[CB_CLR_D];
        clr_req[ST_TAG]  = cfg_we && cfg_wdata[CB_CLR_T];
        set_req[ST_DATA] = set_data_err;
        set_req[ST_TAG]  = set_tag_err;
    end

    // Hold the control bits written through the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.chk_en   <= cfg_wdata[CB_CHK];
            cfg_q.esc_en   <= cfg_wdata[CB_ESC];
            cfg_q.inj_data <= cfg_wdata[CB_INJ_D];
            cfg_q.inj_tag  <= cfg_wdata[CB_INJ_T];
        end
    end

    // One sticky flop per status bit; set has priority over clear
    for (genvar s = 0; s < ST_W; s++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[s] <= 1'b0;
            else if (set_req[s])
                status_q[s] <= 1'b1;
            else if (clr_req[s])
                status_q[s] <= 1'b0;
        end
    end
endmodule

// File: rtl/icp_store.sv
// Direct-mapped entry storage with parity generation on fill.
// Assumes one fill per cycle; reads are combinational by index and see
// the contents from before a same-cycle fill.
module icp_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inj_data,
    input  logic              inj_tag,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_tag_par,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_par
);
    localparam int DEPTH = 1 << IDX_W;

    logic              valid_q [DEPTH];
    logic [TAG_W-1:0]  tag_q   [DEPTH];
    logic              tpar_q  [DEPTH];
    logic [DATA_W-1:0] data_q  [DEPTH];
    logic              dpar_q  [DEPTH];
    logic              wr_tpar;
    logic              wr_dpar;

    // Even parity of the written fields, optionally inverted for test
    always_comb begin
        wr_tpar = (^fill_tag)  ^ inj_tag;
        wr_dpar = (^fill_data) ^ inj_data;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic hit_wr;
        assign hit_wr = fill_valid && (fill_idx == IDX_W'(e));

        // Write one entry when the fill targets its index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                tpar_q[e]  <= 1'b0;
                data_q[e]  <= '0;
                dpar_q[e]  <= 1'b0;
            end else if (hit_wr) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= fill_tag;
                tpar_q[e]  <= wr_tpar;
                data_q[e]  <= fill_data;
                dpar_q[e]  <= wr_dpar;
            end
        end
    end

    // Present the addressed entry to the checker
    always_comb begin
        rd_valid    = valid_q[rd_idx];
        rd_tag      = tag_q[rd_idx];
        rd_tag_par  = tpar_q[rd_idx];
        rd_data     = data_q[rd_idx];
        rd_data_par = dpar_q[rd_idx];
    end
endmodule

// File: rtl/icp_verify.sv
// Tag compare, parity check and registered fetch response.
// Assumes the entry fields are those read in the fetch cycle; a tag
// miss suppresses the data check, while tag parity is checked on any valid entry.
module icp_verify #(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              rd_tag_par,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_data_par,
    input  logic              chk_en,
    input  logic              esc_en,
    output logic              set_data_err,
    output logic              set_tag_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              mcheck
);
    logic hit;
    logic tag_bad;
    logic data_bad;
    logic mc_d;

    // Compare tags and recompute even parity over the stored fields
    always_comb begin
        hit          = rd_valid && (rd_tag == fetch_tag);
        tag_bad      = rd_valid && (^{rd_tag, rd_tag_par});
        data_bad     = hit && (^{rd_data, rd_data_par});
        set_tag_err  = fetch_valid && chk_en && tag_bad;
        set_data_err = fetch_valid && chk_en && data_bad;
        mc_d         = esc_en && (set_tag_err || set_data_err);
    end

    // Register the response and the machine-check pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_hit   <= 1'b0;
            mcheck    <= 1'b0;
        end else begin
            rsp_valid <= fetch_valid;
            rsp_hit   <= fetch_valid && hit;
            rsp_data  <= (fetch_valid && hit) ? rd_data : '0;
            mcheck    <= mc_d;
        end
    end
endmodule

// File: rtl/icache_parity_ctrl.sv
// Top of the instruction cache parity guard: storage, checker, config.
// Assumes address = {tag, index}; speculative fetches are treated the
// same as normal ones, so the flag takes no part in the checks.
module icache_parity_ctrl
    import icp_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_spec,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              fetch_rvalid,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              fetch_hit,
    output logic [ST_W-1:0]   perr_status,
    output logic              mcheck
);
    icp_cfg_t          cfg_q;
    logic              set_data_err;
    logic              set_tag_err;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_tag_par;
    logic [DATA_W-1:0] rd_data;
    logic              rd_data_par;
    logic              spec_unused;

    // The speculative flag does not change checking
    assign spec_unused = fetch_spec;

    icp_cfg_regs cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .set_data_err (set_data_err),
        .set_tag_err  (set_tag_err),
        .cfg_q        (cfg_q),
        .status_q     (perr_status)
    );

    icp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_valid  (fill_valid),
        .fill_idx    (fill_addr[IDX_W-1:0]),
        .fill_tag    (fill_addr[ADDR_W-1:IDX_W]),
        .fill_data   (fill_data),
        .inj_data    (cfg_q.inj_data),
        .inj_tag     (cfg_q.inj_tag),
        .rd_idx      (fetch_addr[IDX_W-1:0]),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_tag),
        .rd_tag_par  (rd_tag_par),
        .rd_data     (rd_data),
        .rd_data_par (rd_data_par)
    );

    icp_verify #(.TAG_W(TAG_W), .DATA_W(DATA_W)) verify_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_tag    (fetch_addr[ADDR_W-1:IDX_W]),
        .rd_valid     (rd_valid),
        .rd_tag       (rd_tag),
        .rd_tag_par   (rd_tag_par),
        .rd_data      (rd_data),
        .rd_data_par  (rd_data_par),
        .chk_en       (cfg_q.chk_en),
        .esc_en       (cfg_q.esc_en),
        .set_data_err (set_data_err),
        .set_tag_err  (set_tag_err),
        .rsp_valid    (fetch_rvalid),
        .rsp_data     (fetch_rdata),
        .rsp_hit      (fetch_hit),
        .mcheck       (mcheck)
    );
endmodule

// File: rtl/icp_sva.sv
// Temporal checks for the instruction cache parity guard, bound to the top.
module icp_sva
    import icp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             fetch_rvalid,
    input logic [ST_W-1:0]  perr_status,
    input logic             mcheck,
    input logic             chk_en,
    input logic             esc_en
);
    // R1
    rsp_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> fetch_rvalid);

    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !fetch_rvalid);

    // R8
    mc_needs_both_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcheck |-> $past(chk_en && esc_en));

    // R8
    mc_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcheck |-> fetch_rvalid);

    // R7
    status_rise_needs_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((perr_status & ~$past(perr_status)) != '0) |-> $past(chk_en && fetch_valid));

    // R10
    data_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(perr_status[ST_DATA]) && !$past(cfg_we && cfg_wdata[CB_CLR_D]))
        |-> perr_status[ST_DATA]);

    // R10
    tag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(perr_status[ST_TAG]) && !$past(cfg_we && cfg_wdata[CB_CLR_T]))
        |-> perr_status[ST_TAG]);
endmodule

bind icache_parity_ctrl icp_sva sva_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .fetch_rvalid (fetch_rvalid),
    .perr_status  (perr_status),
    .mcheck       (mcheck),
    .chk_en       (cfg_q.chk_en),
    .esc_en       (cfg_q.esc_en)
);

// File: tb/icache_parity_ctrl_tb_top.sv
module icache_parity_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic [11:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        fetch_valid = 1'b0;
    logic [11:0] fetch_addr = '0;
    logic        fetch_spec = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        fetch_rvalid;
    logic [31:0] fetch_rdata;
    logic        fetch_hit;
    logic [1:0]  perr_status;
    logic        mcheck;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_ADDR  = 12'h123;
    localparam logic [11:0] B_ADDR  = 12'h4A5;
    localparam logic [11:0] B_MISS  = 12'h7B5;
    localparam logic [11:0] C_ADDR  = 12'h3C7;
    localparam logic [11:0] C_MISS  = 12'h9D7;

    always #5 clk = ~clk;

    icache_parity_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_spec(fetch_spec),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata), .fetch_hit(fetch_hit),
        .perr_status(perr_status), .mcheck(mcheck)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_cfg(logic [5:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // After return, outputs show the response to this fetch
    task automatic do_fetch(logic [11:0] a, logic spec);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a; fetch_spec = spec;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_spec = 1'b0;
    endtask

    task automatic t_reset();
        check("R11", "rvalid", 32'(fetch_rvalid), 0);
        check("R11", "hit", 32'(fetch_hit), 0);
        check("R11", "rdata", fetch_rdata, 0);
        check("R11", "status", 32'(perr_status), 0);
        check("R11", "mcheck", 32'(mcheck), 0);
        do_fetch(A_ADDR, 1'b0);
        check("R11", "empty entry hit", 32'(fetch_hit), 0);
        check("R1", "rvalid", 32'(fetch_rvalid), 1);
    endtask

    task automatic t_fill_hit();
        do_fill(A_ADDR, 32'hDEAD_BEEF);
        do_fetch(A_ADDR, 1'b0);
        check("R1", "hit", 32'(fetch_hit), 1);
        check("R1", "rdata", fetch_rdata, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R1", "rvalid drops", 32'(fetch_rvalid), 0);
    endtask

    task automatic t_miss();
        do_fetch(12'h7F3, 1'b0);
        check("R2", "tag miss hit", 32'(fetch_hit), 0);
        check("R2", "tag miss data", fetch_rdata, 0);
    endtask

    task automatic t_clean_fill();
        do_cfg(6'h00);
        do_fill(C_ADDR, 32'h0000_0007);
        do_cfg(6'h01);
        do_fetch(C_ADDR, 1'b0);
        check("R3", "clean status", 32'(perr_status), 0);
        check("R3", "clean hit", 32'(fetch_hit), 1);
    endtask

    task automatic t_inj_data();
        do_cfg(6'h05);
        do_fill(B_ADDR, 32'h1234_5678);
        do_cfg(6'h01);
        do_fetch(B_MISS, 1'b0);
        check("R6", "miss no data err", 32'(perr_status), 0);
        do_fetch(B_ADDR, 1'b0);
        check("R4", "data err", 32'(perr_status), 1);
        check("R4", "data ok", fetch_rdata, 32'h1234_5678);
        check("R8", "no mc w/o esc", 32'(mcheck), 0);
        do_cfg(6'h11);
        check("R10", "clear data", 32'(perr_status), 0);
    endtask

    task automatic t_inj_tag();
        do_cfg(6'h09);
        do_fill(C_ADDR, 32'hCAFE_0001);
        do_cfg(6'h01);
        do_fetch(C_MISS, 1'b0);
        check("R5", "tag err on miss", 32'(perr_status), 2);
        check("R5", "miss hit", 32'(fetch_hit), 0);
        do_fetch(B_ADDR, 1'b0);
        check("R10", "both set", 32'(perr_status), 3);
        do_cfg(6'h11);
        check("R10", "data clear keeps tag", 32'(perr_status), 2);
        do_cfg(6'h21);
        check("R10", "tag clear", 32'(perr_status), 0);
    endtask

    task automatic t_disabled();
        do_cfg(6'h02);
        do_fetch(B_ADDR, 1'b0);
        check("R7", "esc only status", 32'(perr_status), 0);
        check("R7", "esc only mc", 32'(mcheck), 0);
        do_cfg(6'h00);
        do_fetch(C_MISS, 1'b0);
        check("R7", "off status", 32'(perr_status), 0);
    endtask

    task automatic t_mcheck();
        do_cfg(6'h03);
        do_fetch(B_ADDR, 1'b1);
        check("R9", "spec flagged", 32'(perr_status), 1);
        check("R8", "mc pulse", 32'(mcheck), 1);
        @(negedge clk);
        check("R8", "mc one cycle", 32'(mcheck), 0);
        do_cfg(6'h03);
        check("R10", "no clear keeps", 32'(perr_status), 1);
        do_cfg(6'h13);
        check("R10", "clear", 32'(perr_status), 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = B_ADDR;
        cfg_we = 1'b1; cfg_wdata = 6'h13;
        @(negedge clk);
        fetch_valid = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        check("R10", "set beats clear", 32'(perr_status), 1);
        do_cfg(6'h11);
        do_fill(B_ADDR, 32'h1234_5678);
        do_fetch(B_ADDR, 1'b0);
        check("R3", "refill clean", 32'(perr_status), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_miss();
        t_clean_fill();
        t_inj_data();
        t_inj_tag();
        t_disabled();
        t_mcheck();
        t_set_wins();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule